// File: doc/BRIEF.md
# Exception Request and Vector Selector

This block sits at the instruction boundary of a simple in-order core. On each clock it looks at the instruction completing in that cycle, the current status word, a hardware breakpoint trigger and a pending interrupt level. It then decides whether an exception must be taken. When one is taken it raises a single take strobe for that cycle, gives the 8-bit vector number, and passes on a status word with supervisor mode forced on. Only one exception is taken per boundary. A lower-ranked condition that loses in that cycle is dropped, not remembered.

The block also tracks a stopped state. A stop-type instruction that completes without faulting parks the core and does not raise trace. While the core is parked, no instruction completes. An interrupt whose level passes the status mask, or a breakpoint, releases the core. The debug vector is a fixed internal constant and needs no acknowledge cycle. The interrupt vector comes in on an input bus. All outputs are registered, so they appear one clock after the inputs that cause them.

Top module: `exc_vector_sel`

## Requirements
- R1: During reset and in the first cycle after it, take_exc is 0, exc_vector is 0, sr_out is 0 and core_stopped is 0.
- R2: bkpt_trig high in any cycle, whether stopped or running, gives take_exc=1 and exc_vector=12 in the next cycle. It outranks every other condition.
- R3: instr_done with instr_is_priv while sr_in bit 13 (supervisor) is 0 and the core is not stopped gives exc_vector=8 next cycle, unless a breakpoint is present.
- R4: instr_done while sr_in bit 15 (trace) is 1, for an instruction that is not a stop and raises no higher condition, gives exc_vector=9 next cycle.
- R5: A stop instruction (instr_done with instr_is_stop) that raises no higher condition takes no trace exception even with trace set. core_stopped goes to 1 in the next cycle.
- R6: While core_stopped is 1, instr_done has no effect: no privilege or trace exception is taken, and the core stays stopped.
- R7: While stopped, an interrupt is unmasked when irq_level is greater than sr_in bits 10:8, or when irq_level is 7. An unmasked interrupt gives take_exc=1 with exc_vector=irq_vector and clears core_stopped in the next cycle. A masked level leaves the core stopped with no take.
- R8: take_exc is 1 for exactly the cycles that follow a deciding condition. When take_exc is 0, exc_vector is 0.
- R9: sr_out equals the previous cycle's sr_in, with bit 13 forced to 1 whenever take_exc is 1.
- R10: An interrupt level, even an unmasked one, has no effect while the core is not stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_done | input | 1 | An instruction completes in this cycle |
| instr_is_stop | input | 1 | The completing instruction is a stop instruction |
| instr_is_priv | input | 1 | The completing instruction is supervisor-only |
| sr_in | input | 16 | Current status word: bit 15 trace, bit 13 supervisor, bits 10:8 interrupt mask |
| bkpt_trig | input | 1 | Hardware breakpoint trigger |
| irq_level | input | 3 | Pending interrupt level, 0 means none |
| irq_vector | input | 8 | Vector number for the pending interrupt |
| take_exc | output | 1 | An exception is taken (one pulse per decision) |
| exc_vector | output | 8 | Vector number of the taken exception, 0 otherwise |
| sr_out | output | 16 | Status word after the boundary |
| core_stopped | output | 1 | Core is parked by a stop instruction |

## Verification
The only hidden state is the stopped flag, and it reaches the ports at once through core_stopped. A wrong value also shows one cycle later in how instr_done and irq_level are handled: a core that is wrongly stopped drops privilege and trace exceptions, and a core that is wrongly running ignores unmasked interrupts. Priority or masking errors show as a wrong exc_vector on the cycle after the conflict. A comparison on every clock against an independent reference therefore catches each fault within one or two cycles.

// File: rtl/exc_pkg.sv
// Package: shared constants and the cause encoding for the exception selector.
// Assumes a 16-bit status word with trace, supervisor and mask fields at fixed bits.
package exc_pkg;

    localparam int SR_W        = 16;
    localparam int VEC_W       = 8;
    localparam int LVL_W       = 3;

    localparam int SR_TRACE_BIT = 15;
    localparam int SR_SUPER_BIT = 13;
    localparam int SR_MASK_LO   = 8;

    localparam logic [VEC_W-1:0] VEC_PRIV  = 8'd8;
    localparam logic [VEC_W-1:0] VEC_TRACE = 8'd9;
    localparam logic [VEC_W-1:0] VEC_DEBUG = 8'd12;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_DEBUG = 3'd1,
        CAUSE_IRQ   = 3'd2,
        CAUSE_PRIV  = 3'd3,
        CAUSE_TRACE = 3'd4
    } exc_cause_e;

endpackage

// File: rtl/exc_irq_gate.sv
// Module: exc_irq_gate
// Decides whether a pending interrupt level passes the status mask.
// Assumes level 0 means no request. When TOP_BYPASS is set, the highest
// level passes whatever the mask holds.
module exc_irq_gate #(
    parameter int LVL_W      = 3,
    parameter bit TOP_BYPASS = 1'b1
) (
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] mask,
    output logic             unmasked
);
    localparam logic [LVL_W-1:0] LVL_TOP = {LVL_W{1'b1}};

    logic above_mask;

    // Compare the request level against the mask field.
    always_comb begin
        above_mask = (level > mask);
    end

    generate
        if (TOP_BYPASS) begin : g_top_bypass
            // Highest level cannot be masked.
            always_comb begin
                unmasked = above_mask || (level == LVL_TOP);
            end
        end else begin : g_plain
            // Pure mask comparison.
            always_comb begin
                unmasked = above_mask;
            end
        end
    endgenerate
endmodule

// File: rtl/exc_prio_pick.sv
// Module: exc_prio_pick
// Fixed-priority choice among the conditions seen at one boundary:
// breakpoint, then interrupt release, then privilege violation, then trace.
// Assumes the inputs are already qualified by the stopped state.
module exc_prio_pick
    import exc_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             debug_req,
    input  logic             irq_req,
    input  logic             priv_req,
    input  logic             trace_req,
    input  logic [VEC_W-1:0] irq_vec,
    output logic             take,
    output logic [VEC_W-1:0] vec,
    output exc_cause_e       cause
);
    // Select the winning cause and its vector number.
    always_comb begin
        take  = 1'b1;
        vec   = '0;
        cause = CAUSE_NONE;
        if (debug_req) begin
            cause = CAUSE_DEBUG;
            vec   = VEC_DEBUG;
        end else if (irq_req) begin
            cause = CAUSE_IRQ;
            vec   = irq_vec;
        end else if (priv_req) begin
            cause = CAUSE_PRIV;
            vec   = VEC_PRIV;
        end else if (trace_req) begin
            cause = CAUSE_TRACE;
            vec   = VEC_TRACE;
        end else begin
            take  = 1'b0;
        end
    end
endmodule

// File: rtl/exc_stop_tracker.sv
// Module: exc_stop_tracker
// Holds the parked state entered by a stop instruction.
// Assumes any taken exception releases the core, and takes priority over entry.
module exc_stop_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_done,
    input  logic take,
    output logic stopped
);
    // Set on a clean stop completion, clear on any exception.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stopped <= 1'b0;
        end else if (take) begin
            stopped <= 1'b0;
        end else if (stop_done && !stopped) begin
            stopped <= 1'b1;
        end
    end
endmodule

// File: rtl/exc_vector_sel.sv
// Module: exc_vector_sel (top)
// Picks at most one exception per instruction boundary and registers the
// take strobe, the vector number and the status word with supervisor set.
// Assumes the sources of instr_done/is_stop/is_priv are valid in one cycle.
module exc_vector_sel
    import exc_pkg::*;
#(
    parameter int SR_W_P  = SR_W,
    parameter int VEC_W_P = VEC_W,
    parameter int LVL_W_P = LVL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_done,
    input  logic               instr_is_stop,
    input  logic               instr_is_priv,
    input  logic [SR_W_P-1:0]  sr_in,
    input  logic               bkpt_trig,
    input  logic [LVL_W_P-1:0] irq_level,
    input  logic [VEC_W_P-1:0] irq_vector,
    output logic               take_exc,
    output logic [VEC_W_P-1:0] exc_vector,
    output logic [SR_W_P-1:0]  sr_out,
    output logic               core_stopped
);
    localparam int MASK_HI = SR_MASK_LO + LVL_W_P - 1;

    logic               stopped;
    logic               irq_pass;
    logic               done_run;
    logic               debug_req;
    logic               irq_req;
    logic               priv_req;
    logic               trace_req;
    logic               pick_take;
    logic [VEC_W_P-1:0] pick_vec;
    exc_cause_e         pick_cause;

    exc_irq_gate #(.LVL_W(LVL_W_P), .TOP_BYPASS(1'b1)) u_gate (
        .level    (irq_level),
        .mask     (sr_in[MASK_HI:SR_MASK_LO]),
        .unmasked (irq_pass)
    );

    // Qualify each request with the stopped state.
    always_comb begin
        done_run  = instr_done && !stopped;
        debug_req = bkpt_trig;
        irq_req   = stopped && irq_pass;
        priv_req  = done_run && instr_is_priv && !sr_in[SR_SUPER_BIT];
        trace_req = done_run && sr_in[SR_TRACE_BIT] && !instr_is_stop;
    end

    exc_prio_pick #(.VEC_W(VEC_W_P)) u_pick (
        .debug_req (debug_req),
        .irq_req   (irq_req),
        .priv_req  (priv_req),
        .trace_req (trace_req),
        .irq_vec   (irq_vector),
        .take      (pick_take),
        .vec       (pick_vec),
        .cause     (pick_cause)
    );

    exc_stop_tracker u_stop (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_done (done_run && instr_is_stop),
        .take      (pick_take),
        .stopped   (stopped)
    );

    // Register the decision and the status word handed to the next stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_exc   <= 1'b0;
            exc_vector <= '0;
            sr_out     <= '0;
        end else begin
            take_exc   <= pick_take;
            exc_vector <= pick_vec;
            sr_out     <= sr_in;
            if (pick_take) begin
                sr_out[SR_SUPER_BIT] <= 1'b1;
            end
        end
    end

    // Bring the parked state to the port.
    always_comb begin
        core_stopped = stopped;
    end

    logic unused_cause;
    always_comb unused_cause = ^pick_cause;
endmodule

// File: rtl/exc_vector_sel_chk.sv
// Module: exc_vector_sel_chk
// Port-level properties of the exception selector, bound to every instance.
module exc_vector_sel_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_done,
    input logic        instr_is_stop,
    input logic        instr_is_priv,
    input logic [15:0] sr_in,
    input logic        bkpt_trig,
    input logic        take_exc,
    input logic [7:0]  exc_vector,
    input logic [15:0] sr_out,
    input logic        core_stopped
);
    AST_DEBUG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_trig |=> (take_exc && exc_vector == 8'd12)); // R2

    AST_PRIV_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && instr_is_priv && !sr_in[13] && !bkpt_trig && !core_stopped)
        |=> (take_exc && exc_vector == 8'd8)); // R3

    AST_IDLE_VECTOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !take_exc |-> (exc_vector == 8'd0)); // R8

    AST_TAKE_SUPERVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |-> sr_out[13]); // R9

    AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_stopped) |-> ($past(instr_done && instr_is_stop) && !take_exc)); // R5

    AST_RELEASE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_stopped) |-> take_exc); // R7
endmodule

bind exc_vector_sel exc_vector_sel_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_done    (instr_done),
    .instr_is_stop (instr_is_stop),
    .instr_is_priv (instr_is_priv),
    .sr_in         (sr_in),
    .bkpt_trig     (bkpt_trig),
    .take_exc      (take_exc),
    .exc_vector    (exc_vector),
    .sr_out        (sr_out),
    .core_stopped  (core_stopped)
);

// File: tb/test_exc_vector_sel.sv
// Bench: behavioural reference model compared with the design on every clock.
module test_exc_vector_sel;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_done = 1'b0;
    logic        instr_is_stop = 1'b0;
    logic        instr_is_priv = 1'b0;
    logic [15:0] sr_in = 16'h0;
    logic        bkpt_trig = 1'b0;
    logic [2:0]  irq_level = 3'd0;
    logic [7:0]  irq_vector = 8'd0;
    logic        take_exc;
    logic [7:0]  exc_vector;
    logic [15:0] sr_out;
    logic        core_stopped;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done_flag = 1'b0;

    // reference state
    bit        m_take = 0;
    int        m_vec = 0;
    int        m_sr = 0;
    bit        m_stop = 0;
    string     m_tag = "R1";
    bit        unm;

    exc_vector_sel i_exc_vector_sel (
        .clk(clk), .rst_n(rst_n), .instr_done(instr_done),
        .instr_is_stop(instr_is_stop), .instr_is_priv(instr_is_priv),
        .sr_in(sr_in), .bkpt_trig(bkpt_trig), .irq_level(irq_level),
        .irq_vector(irq_vector), .take_exc(take_exc), .exc_vector(exc_vector),
        .sr_out(sr_out), .core_stopped(core_stopped)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model, written from the requirements.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_take = 0; m_vec = 0; m_sr = 0; m_stop = 0; m_tag = "R1";
        end else begin
            unm = (irq_level == 3'd7) || (int'(irq_level) > int'(sr_in[10:8]));
            m_take = 1;
            if (bkpt_trig) begin
                m_vec = 12; m_tag = "R2";
            end else if (m_stop && unm) begin
                m_vec = irq_vector; m_tag = "R7";
            end else if (!m_stop && instr_done && instr_is_priv && !sr_in[13]) begin
                m_vec = 8; m_tag = "R3";
            end else if (!m_stop && instr_done && sr_in[15] && !instr_is_stop) begin
                m_vec = 9; m_tag = "R4";
            end else begin
                m_take = 0; m_vec = 0;
                if (m_stop) m_tag = instr_done ? "R6" : "R7";
                else if (instr_done && instr_is_stop) m_tag = "R5";
                else if (unm && irq_level != 0) m_tag = "R10";
                else m_tag = "R8";
            end
            m_sr = sr_in | (m_take ? 16'h2000 : 16'h0);
            if (m_take) m_stop = 0;
            else if (instr_done && instr_is_stop) m_stop = 1;
        end
    end

    task automatic check_now();
        checks++;
        if (take_exc !== m_take || int'(exc_vector) != m_vec) begin
            failures++;
            $display("FAIL %s take/vec actual=%0b/%0d expected=%0b/%0d", m_tag,
                     take_exc, exc_vector, m_take, m_vec);
        end
        checks++;
        if (int'(sr_out) != m_sr) begin
            failures++;
            $display("FAIL R9 sr_out actual=%h expected=%h", sr_out, m_sr[15:0]);
        end
        checks++;
        if (core_stopped !== m_stop) begin
            failures++;
            $display("FAIL %s core_stopped actual=%0b expected=%0b", m_tag,
                     core_stopped, m_stop);
        end
    endtask

    // Apply one cycle of stimulus, then compare after the edge.
    task automatic step(input bit d, input bit s, input bit p, input bit b,
                        input logic [2:0] lvl, input logic [7:0] iv,
                        input logic [15:0] sr);
        instr_done = d; instr_is_stop = s; instr_is_priv = p; bkpt_trig = b;
        irq_level = lvl; irq_vector = iv; sr_in = sr;
        @(negedge clk);
        check_now();
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check_now(); // R1 during reset
        rst_n = 1'b1;
        step(0, 0, 0, 0, 3'd0, 8'd0, 16'h0000); // R1 first cycle out of reset
        // R3 user-mode privileged instruction, R4 trace below it
        step(1, 0, 1, 0, 3'd0, 8'd0, 16'h8000);
        step(1, 0, 0, 0, 3'd0, 8'd0, 16'h8000); // R4
        step(1, 0, 1, 1, 3'd0, 8'd0, 16'h8000); // R2 over R3
        step(0, 0, 0, 0, 3'd7, 8'd70, 16'h2000); // R10 running, irq ignored
        // R5 stop with trace set, then R6 and R7
        step(1, 1, 0, 0, 3'd0, 8'd0, 16'ha700);
        step(1, 0, 1, 0, 3'd0, 8'd0, 16'h8300); // R6 ignored while stopped
        step(0, 0, 0, 0, 3'd3, 8'd77, 16'h2300); // R7 masked (3 not > 3)
        step(0, 0, 0, 0, 3'd4, 8'd78, 16'h2300); // R7 release
        step(1, 1, 0, 0, 3'd0, 8'd0, 16'h2700);  // R5
        step(0, 0, 0, 0, 3'd7, 8'd99, 16'h2700); // R7 level 7 bypasses mask
        step(1, 1, 0, 0, 3'd0, 8'd0, 16'h2000);
        step(0, 0, 0, 1, 3'd0, 8'd0, 16'h2000);  // R2 releases stopped core
        step(1, 1, 1, 0, 3'd0, 8'd0, 16'h8000);  // R3 stop in user mode faults
        step(0, 0, 0, 0, 3'd0, 8'd0, 16'h0000);  // R8 idle
        for (int k = 0; k < 3000; k++) begin
            step(($urandom % 4) != 0, ($urandom % 6) == 0, ($urandom % 4) == 0,
                 ($urandom % 20) == 0, 3'($urandom % 8), 8'(64 + $urandom % 192),
                 {1'($urandom), 2'b00, 1'($urandom), 2'b00, 3'($urandom), 8'($urandom)});
        end
        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        if (cycles > WATCHDOG && !done_flag) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule